// File: doc/BRIEF.md
# DMA Channel Allocator with Preferred-Channel Search

This block keeps a usage bitmap for a bank of DMA channels and serves one command per clock. A command can claim a named channel as an atomic test-and-set, claim a channel by naming a preferred one together with a mask of acceptable alternatives, release a channel, or ask whether a channel is taken. Every command also reports the transfer bus width of the channel it names. Channels below a split index are narrow (8-bit), and channels at or above it are wide (16-bit).

A preferred request grants the named channel if that channel exists and is free. The mask is not consulted for the preferred channel. If the preferred channel cannot be used, the block grants the lowest-numbered channel that is both free and enabled in the mask. The bitmap and the response register update on the same clock edge, so two requests on consecutive cycles can never receive the same channel. One channel is marked in use from reset because it is held for cascading.

Top module: `chan_alloc`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `usage_map` equals 8'h10 (only channel 4 in use), and `rsp_valid` is 0.
- R2: A command accepted with `cmd_valid` high at a clock edge produces `rsp_valid`=1 and `rsp_op` equal to `cmd_op` in the following cycle. With no command, `rsp_valid` is 0 in the following cycle.
- R3: Op 0 (take) on a valid index sets `rsp_busy` to the old usage bit. If that bit was clear, the block sets it and answers `rsp_fail`=0 with `rsp_chan` equal to the index. If it was set, the block answers `rsp_fail`=1.
- R4: Op 1 (prefer) grants `cmd_chan` when it is below 8 and free, whatever `cmd_mask` holds.
- R5: Otherwise op 1 grants the lowest index i for which `cmd_mask[i]`=1 and channel i is free.
- R6: Any failed command returns `rsp_chan`=4'hF and `rsp_fail`=1, and leaves `usage_map` unchanged.
- R7: A grant sets the channel's bit in `usage_map` on the same edge that presents the response, so back-to-back prefer requests receive distinct channels.
- R8: Op 2 (release) clears the bit of a valid index and reports the old bit in `rsp_busy`. An index of 8 or above is ignored, with `rsp_fail`=1.
- R9: Op 3 (probe) returns the usage bit in `rsp_busy` and never changes `usage_map`. An index of 8 or above gives `rsp_fail`=1 and `rsp_busy`=0.
- R10: For every op, `rsp_width` is 8 for indices 0 to 3, 16 for indices 4 to 7, and 0 with `rsp_err`=1 for indices 8 to 15. `rsp_err` is 0 for valid indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 take, 1 prefer, 2 release, 3 probe |
| cmd_chan | input | 4 | Channel index (preferred channel for op 1) |
| cmd_mask | input | 8 | Allowed fallback channels for op 1 |
| rsp_valid | output | 1 | Response present |
| rsp_op | output | 2 | Op the response belongs to |
| rsp_chan | output | 4 | Granted or named channel, all ones on failure |
| rsp_fail | output | 1 | Command failed |
| rsp_busy | output | 1 | Usage bit of the named channel before the command |
| rsp_width | output | 5 | Bus width of the named channel |
| rsp_err | output | 1 | Named index out of range |
| usage_map | output | 8 | Current usage bitmap |

## Verification
The bench builds the block with its default parameters: eight channels, channel 4 reserved, and wide channels from index 4 up. With a 4-bit index, the out-of-range values 8 to 15 can be driven, which exercises the error width and the ignored release. Eight channels are few enough that the directed sequence can fill the bitmap completely. That reaches the preferred-then-lowest fallback, the all-taken failure, and back-to-back grants against a full map.

// File: rtl/chan_alloc_pkg.sv
package chan_alloc_pkg;

    typedef enum logic [1:0] {
        OP_TAKE    = 2'd0,
        OP_PREFER  = 2'd1,
        OP_RELEASE = 2'd2,
        OP_PROBE   = 2'd3
    } alloc_op_e;

    localparam int DEF_NUM_CH   = 8;
    localparam int DEF_RSV_CH   = 4;
    localparam int DEF_WIDE_MIN = 4;
    localparam int DEF_NARROW_W = 8;
    localparam int DEF_WIDE_W   = 16;

    function automatic logic op_grants(alloc_op_e op);
        return (op == OP_TAKE) || (op == OP_PREFER);
    endfunction

endpackage

// File: rtl/chan_pick.sv
module chan_pick #(
    parameter int NUM_CH = 8,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] used_i,
    input  logic [NUM_CH-1:0] mask_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [NUM_CH-1:0] cand;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
        assign cand[g] = mask_i[g] & ~used_i[g];
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/chan_bus_width.sv
module chan_bus_width #(
    parameter int NUM_CH   = 8,
    parameter int WIDE_MIN = 4,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    localparam int CIDX_W  = $clog2(NUM_CH) + 1,
    localparam int WW      = $clog2(WIDE_W + 1)
) (
    input  logic [CIDX_W-1:0] chan_i,
    output logic [WW-1:0]     width_o,
    output logic              err_o
);
    always_comb begin
        if (int'(chan_i) >= NUM_CH) begin
            width_o = '0;
            err_o   = 1'b1;
        end else if (int'(chan_i) >= WIDE_MIN) begin
            width_o = WW'(WIDE_W);
            err_o   = 1'b0;
        end else begin
            width_o = WW'(NARROW_W);
            err_o   = 1'b0;
        end
    end
endmodule

// File: rtl/chan_alloc.sv
module chan_alloc
    import chan_alloc_pkg::*;
#(
    parameter int NUM_CH   = DEF_NUM_CH,
    parameter int RSV_CH   = DEF_RSV_CH,
    parameter int WIDE_MIN = DEF_WIDE_MIN,
    parameter int NARROW_W = DEF_NARROW_W,
    parameter int WIDE_W   = DEF_WIDE_W,
    localparam int IDX_W   = $clog2(NUM_CH),
    localparam int CIDX_W  = IDX_W + 1,
    localparam int WW      = $clog2(WIDE_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CIDX_W-1:0] cmd_chan,
    input  logic [NUM_CH-1:0] cmd_mask,
    output logic              rsp_valid,
    output logic [1:0]        rsp_op,
    output logic [CIDX_W-1:0] rsp_chan,
    output logic              rsp_fail,
    output logic              rsp_busy,
    output logic [WW-1:0]     rsp_width,
    output logic              rsp_err,
    output logic [NUM_CH-1:0] usage_map
);
    localparam logic [NUM_CH-1:0] RESET_MAP = NUM_CH'(1) << RSV_CH;

    typedef struct packed {
        logic              valid;
        alloc_op_e         op;
        logic [CIDX_W-1:0] chan;
        logic              fail;
        logic              busy;
        logic [WW-1:0]     width;
        logic              err;
    } rsp_t;

    rsp_t              rsp_q, rsp_d;
    logic [NUM_CH-1:0] used_q, used_d;

    alloc_op_e        op;
    logic             idx_ok, cur_bit, pick_found;
    logic [IDX_W-1:0] idx, pick_idx;
    logic [WW-1:0]    width;
    logic             width_err;

    assign op     = alloc_op_e'(cmd_op);
    assign idx_ok = int'(cmd_chan) < NUM_CH;
    assign idx    = cmd_chan[IDX_W-1:0];
    assign cur_bit = idx_ok ? used_q[idx] : 1'b0;

    chan_pick #(.NUM_CH(NUM_CH)) u_pick (
        .used_i  (used_q),
        .mask_i  (cmd_mask),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    chan_bus_width #(
        .NUM_CH(NUM_CH), .WIDE_MIN(WIDE_MIN),
        .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
    ) u_width (
        .chan_i  (cmd_chan),
        .width_o (width),
        .err_o   (width_err)
    );

    always_comb begin
        logic             grant;
        logic [IDX_W-1:0] gidx;
        used_d = used_q;
        grant  = 1'b0;
        gidx   = idx;

        rsp_d       = '0;
        rsp_d.valid = cmd_valid;
        rsp_d.op    = op;
        rsp_d.busy  = cur_bit;
        rsp_d.width = width;
        rsp_d.err   = width_err;
        rsp_d.fail  = 1'b1;
        rsp_d.chan  = '1;

        if (cmd_valid) begin
            unique case (op)
                OP_TAKE: begin
                    grant = idx_ok && !cur_bit;
                end
                OP_PREFER: begin
                    if (idx_ok && !cur_bit) begin
                        grant = 1'b1;
                    end else if (pick_found) begin
                        grant = 1'b1;
                        gidx  = pick_idx;
                    end
                end
                OP_RELEASE: begin
                    if (idx_ok) begin
                        used_d[idx] = 1'b0;
                        rsp_d.fail  = 1'b0;
                        rsp_d.chan  = cmd_chan;
                    end
                end
                OP_PROBE: begin
                    if (idx_ok) begin
                        rsp_d.fail = 1'b0;
                        rsp_d.chan = cmd_chan;
                    end
                end
                default: ;
            endcase

            if (op_grants(op) && grant) begin
                used_d[gidx] = 1'b1;
                rsp_d.fail   = 1'b0;
                rsp_d.chan   = {1'b0, gidx};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= RESET_MAP;
            rsp_q  <= '0;
        end else begin
            used_q <= used_d;
            rsp_q  <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_op    = rsp_q.op;
    assign rsp_chan  = rsp_q.chan;
    assign rsp_fail  = rsp_q.fail;
    assign rsp_busy  = rsp_q.busy;
    assign rsp_width = rsp_q.width;
    assign rsp_err   = rsp_q.err;
    assign usage_map = used_q;
endmodule

// File: rtl/chan_alloc_chk.sv
module chan_alloc_chk #(
    parameter int NUM_CH = 8,
    parameter int RSV_CH = 4,
    localparam int IDX_W  = $clog2(NUM_CH),
    localparam int CIDX_W = IDX_W + 1,
    localparam int WW     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              rsp_valid,
    input logic [1:0]        rsp_op,
    input logic [CIDX_W-1:0] rsp_chan,
    input logic              rsp_fail,
    input logic [WW-1:0]     rsp_width,
    input logic              rsp_err,
    input logic [NUM_CH-1:0] usage_map
);
    localparam logic [NUM_CH-1:0] RESET_MAP = NUM_CH'(1) << RSV_CH;

    logic [NUM_CH-1:0] prev_map;
    always_ff @(posedge clk) prev_map <= usage_map;

    // R1
    reset_map_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (usage_map == RESET_MAP && !rsp_valid));

    // R2
    rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (rsp_valid && rsp_op == $past(cmd_op)));

    // R6
    fail_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fail) |-> (rsp_chan == '1));

    // R7
    grant_marked_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fail && (rsp_op == 2'd0 || rsp_op == 2'd1))
        |-> usage_map[rsp_chan[IDX_W-1:0]]);

    // R4
    grant_was_free_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fail && rsp_op == 2'd1 && !$past(rst))
        |-> !prev_map[rsp_chan[IDX_W-1:0]]);

    // R9
    probe_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd3) |=> $stable(usage_map));

    // R10
    err_width_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_width == '0));
endmodule

bind chan_alloc chan_alloc_chk #(.NUM_CH(NUM_CH), .RSV_CH(RSV_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_op    (rsp_op),
    .rsp_chan  (rsp_chan),
    .rsp_fail  (rsp_fail),
    .rsp_width (rsp_width),
    .rsp_err   (rsp_err),
    .usage_map (usage_map)
);

// File: tb/tb_chan_alloc.sv
module tb_chan_alloc;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [3:0] cmd_chan = '0;
    logic [7:0] cmd_mask = '0;
    logic       rsp_valid, rsp_fail, rsp_busy, rsp_err;
    logic [1:0] rsp_op;
    logic [3:0] rsp_chan;
    logic [4:0] rsp_width;
    logic [7:0] usage_map;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_alloc dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_chan(cmd_chan), .cmd_mask(cmd_mask), .rsp_valid(rsp_valid),
        .rsp_op(rsp_op), .rsp_chan(rsp_chan), .rsp_fail(rsp_fail),
        .rsp_busy(rsp_busy), .rsp_width(rsp_width), .rsp_err(rsp_err),
        .usage_map(usage_map)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // Drive one command, return with its response on the outputs.
    task automatic issue(input logic [1:0] op, input logic [3:0] ch, input logic [7:0] m);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch; cmd_mask = m;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R1 map in reset", usage_map, 8'h10);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 map after reset", usage_map, 8'h10);
        chk_eq("R1 rsp_valid after reset", rsp_valid, 0);
    endtask

    task automatic t_take();
        issue(2'd0, 4'd2, 8'h00);
        chk_eq("R2 rsp_valid", rsp_valid, 1);
        chk_eq("R2 rsp_op", rsp_op, 0);
        chk_eq("R3 take chan", rsp_chan, 2);
        chk_eq("R3 take fail", rsp_fail, 0);
        chk_eq("R3 take busy", rsp_busy, 0);
        chk_eq("R3 take map", usage_map, 8'h14);
        @(negedge clk);
        chk_eq("R2 idle rsp_valid", rsp_valid, 0);
        issue(2'd0, 4'd2, 8'h00);
        chk_eq("R3 retake busy", rsp_busy, 1);
        chk_eq("R3 retake fail", rsp_fail, 1);
        chk_eq("R6 retake chan", rsp_chan, 4'hF);
        chk_eq("R6 retake map", usage_map, 8'h14);
        issue(2'd0, 4'd4, 8'h00);
        chk_eq("R3 reserved busy", rsp_busy, 1);
        chk_eq("R3 reserved fail", rsp_fail, 1);
    endtask

    task automatic t_prefer();
        issue(2'd1, 4'd3, 8'h00);
        chk_eq("R4 pref ignores mask chan", rsp_chan, 3);
        chk_eq("R4 pref fail", rsp_fail, 0);
        chk_eq("R4 pref map", usage_map, 8'h1C);
        issue(2'd1, 4'd3, 8'hF0);
        chk_eq("R5 fallback chan", rsp_chan, 5);
        chk_eq("R5 fallback map", usage_map, 8'h3C);
        issue(2'd1, 4'd9, 8'h0F);
        chk_eq("R5 invalid pref scans", rsp_chan, 0);
        chk_eq("R10 invalid pref err", rsp_err, 1);
        chk_eq("R10 invalid pref width", rsp_width, 0);
        issue(2'd1, 4'd2, 8'h06);
        chk_eq("R5 lowest allowed", rsp_chan, 1);
        chk_eq("R5 map", usage_map, 8'h3F);
        issue(2'd1, 4'd0, 8'h3F);
        chk_eq("R6 none fail", rsp_fail, 1);
        chk_eq("R6 none chan", rsp_chan, 4'hF);
        chk_eq("R6 none map", usage_map, 8'h3F);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_chan = 4'd7; cmd_mask = 8'hFF;
        @(negedge clk);
        chk_eq("R7 first grant", rsp_chan, 7);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk_eq("R7 second grant distinct", rsp_chan, 6);
        chk_eq("R7 second fail", rsp_fail, 0);
        chk_eq("R7 map full", usage_map, 8'hFF);
    endtask

    task automatic t_release_probe();
        issue(2'd2, 4'd5, 8'h00);
        chk_eq("R8 release busy", rsp_busy, 1);
        chk_eq("R8 release fail", rsp_fail, 0);
        chk_eq("R8 release map", usage_map, 8'hDF);
        issue(2'd3, 4'd5, 8'h00);
        chk_eq("R9 probe free", rsp_busy, 0);
        chk_eq("R9 probe map", usage_map, 8'hDF);
        issue(2'd3, 4'd6, 8'h00);
        chk_eq("R9 probe used", rsp_busy, 1);
        chk_eq("R9 probe chan", rsp_chan, 6);
        issue(2'd2, 4'd12, 8'h00);
        chk_eq("R8 invalid release fail", rsp_fail, 1);
        chk_eq("R8 invalid release map", usage_map, 8'hDF);
        issue(2'd3, 4'd13, 8'h00);
        chk_eq("R9 invalid probe fail", rsp_fail, 1);
        chk_eq("R9 invalid probe busy", rsp_busy, 0);
    endtask

    task automatic t_width();
        issue(2'd3, 4'd0, 8'h00);
        chk_eq("R10 narrow width", rsp_width, 8);
        chk_eq("R10 narrow err", rsp_err, 0);
        issue(2'd3, 4'd3, 8'h00);
        chk_eq("R10 narrow top width", rsp_width, 8);
        issue(2'd3, 4'd4, 8'h00);
        chk_eq("R10 wide low width", rsp_width, 16);
        issue(2'd3, 4'd7, 8'h00);
        chk_eq("R10 wide width", rsp_width, 16);
        issue(2'd3, 4'd15, 8'h00);
        chk_eq("R10 bad width", rsp_width, 0);
        chk_eq("R10 bad err", rsp_err, 1);
    endtask

    initial begin
        t_reset();
        t_take();
        t_prefer();
        t_back_to_back();
        t_release_probe();
        t_width();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule